// File: doc/BRIEF.md
# Dual-Mode Interval and Seconds Timer

This block is a register-mapped timer for a microcontroller-class subsystem. Software programs it through a small synchronous register bus. It then runs in one of two configurations. The first is a 32-bit down-counter that reloads from a programmed interval and can fire once or repeatedly. The second is a seconds counter that counts up once per second and flags the moment it equals a programmed 32-bit compare value.

Both 32-bit values are held as two 16-bit halves, and the halves are joined to form the count. Status flags are sticky until software clears them. The single interrupt line is the OR of the status flags that the mask lets through. On each down-counter timeout the block can also send a one-cycle strobe to start an analogue-to-digital conversion.

Register words (the address is a word index): 0 configuration [2:0], 1 mode [0], 2 control, 3 interrupt mask, 4 raw status (read), 5 masked status (read), 6 status clear (write), 7 interval, 8 compare, 9 live counter (read). Any other address reads as zero.

Top module: `dmtimer`

## Requirements
- R1: After reset, every register and the live counter read 0, and both `irq_o` and `adc_trig_o` are low.
- R2: With configuration 0, a 0-to-1 change of control bit 0 loads the counter with the interval value, formed as {upper half, lower half}. The counter then steps down once every PRESCALE clocks. Raw status bit 0 sets on the step taken while the count is 1 or 0, so a start with interval N times out N×PRESCALE clocks later, and an interval of 0 acts as 1.
- R3: When mode bit 0 is 0 (periodic), a timeout reloads the interval and the next timeout follows after the same period.
- R4: When mode bit 0 is 1 (one-shot), a timeout stops the counter, forces the counter value to 0 and clears control bit 0. No further timeout follows.
- R5: When control bit 5 is set, each configuration-0 timeout drives `adc_trig_o` high for exactly one clock, in the same cycle that status bit 0 becomes visible. When control bit 5 is clear, `adc_trig_o` stays low.
- R6: With configuration 1, starting clears the counter, and the counter then steps up once every CLKS_PER_SEC clocks. Raw status bit 2 sets on the step that makes the counter equal the compare value. Counting continues after that step.
- R7: A write to the interrupt mask keeps only the bits in 0x77. `irq_o` is high exactly when (raw status AND mask) is nonzero, and the masked-status word reads back that AND.
- R8: Writing the clear word clears each raw-status bit whose data bit is 1. Bits written as 0 are untouched. A flag that sets in the same cycle as its clear stays set.
- R9: A write to the interval or compare word stores data bits 15:0 as the lower half and bits 31:16 as the upper half. A read returns both halves when the configuration is below 4, and only the lower half (upper 16 bits zero) otherwise.
- R10: A 1-to-0 change of control bit 0 freezes the counter with no further status events. A start issued while the configuration is neither 0 nor 1 leaves the counter idle and unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe (qualified by sel_i) |
| addr_i | input | ADDR_W | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt |
| adc_trig_o | output | 1 | One-cycle conversion strobe |

## Verification
On every cycle, the bound checker verifies the following. The conversion strobe never lasts two cycles and appears only when its enable was set. A one-shot timeout always halts the counter. An idle counter never moves. A timeout flag stays set until a clear names it. A zero mask keeps the interrupt low. Other properties need a complete scenario and are shown only by the bench's programmed sequences: the exact timeout cycle for a given interval, the period after a periodic reload, the seconds compare hit, the split-half readback rules and the mask filtering on writes.

// File: rtl/dmtimer_pkg.sv
package dmtimer_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned HW = 16;

    // register word indices
    localparam int A_CFG   = 0;
    localparam int A_MODE  = 1;
    localparam int A_CTRL  = 2;
    localparam int A_IMASK = 3;
    localparam int A_RIS   = 4;
    localparam int A_MIS   = 5;
    localparam int A_ICLR  = 6;
    localparam int A_LOAD  = 7;
    localparam int A_MATCH = 8;
    localparam int A_VALUE = 9;

    // configuration codes
    localparam logic [2:0] CFG_DOWN  = 3'd0;
    localparam logic [2:0] CFG_SECS  = 3'd1;
    localparam logic [2:0] CFG_SPLIT = 3'd4;

    // bit positions
    localparam int ST_TMO   = 0;
    localparam int ST_SECS  = 2;
    localparam int CTRL_RUN = 0;
    localparam int CTRL_TRG = 5;

    localparam logic [7:0] MASK_KEEP = 8'h77;
    localparam logic [5:0] CTRL_KEEP = 6'h21;

    typedef struct packed {
        logic          run;
        logic [DW-1:0] count;
    } core_t;

    typedef struct packed {
        logic [2:0]    cfg;
        logic          oneshot;
        logic [5:0]    ctrl;
        logic [7:0]    mask;
        logic [7:0]    ris;
        logic [HW-1:0] load_lo;
        logic [HW-1:0] load_hi;
        logic [HW-1:0] match_lo;
        logic [HW-1:0] match_hi;
        logic          trig;
    } regs_t;

endpackage

// File: rtl/dmtimer_div.sv
module dmtimer_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dmtimer_core.sv
module dmtimer_core
    import dmtimer_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [2:0]    cfg_i,
    input  logic          oneshot_i,
    input  logic [DW-1:0] load_i,
    input  logic [DW-1:0] match_i,
    input  logic          tick_i,
    input  logic          sec_i,
    output logic          run_o,
    output logic [DW-1:0] count_o,
    output logic          timeout_o,
    output logic          hit_o
);
    core_t         s_d, s_q;
    logic [DW-1:0] inc;

    always_comb begin
        s_d       = s_q;
        timeout_o = 1'b0;
        hit_o     = 1'b0;
        inc       = s_q.count + 32'd1;
        if (start_i) begin
            if (cfg_i == CFG_DOWN) begin
                s_d.run   = 1'b1;
                s_d.count = load_i;
            end else if (cfg_i == CFG_SECS) begin
                s_d.run   = 1'b1;
                s_d.count = '0;
            end
        end else if (stop_i) begin
            s_d.run = 1'b0;
        end else if (s_q.run) begin
            case (cfg_i)
                CFG_DOWN: begin
                    if (tick_i) begin
                        if (s_q.count <= 32'd1) begin
                            timeout_o = 1'b1;
                            if (oneshot_i) begin
                                s_d.run   = 1'b0;
                                s_d.count = '0;
                            end else begin
                                s_d.count = load_i;
                            end
                        end else begin
                            s_d.count = s_q.count - 32'd1;
                        end
                    end
                end
                CFG_SECS: begin
                    if (sec_i) begin
                        s_d.count = inc;
                        hit_o     = (inc == match_i);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign run_o   = s_q.run;
    assign count_o = s_q.count;
endmodule

// File: rtl/dmtimer.sv
module dmtimer
    import dmtimer_pkg::*;
#(
    parameter int unsigned PRESCALE     = 4,
    parameter int unsigned CLKS_PER_SEC = 125_000_000,
    parameter int unsigned ADDR_W       = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              irq_o,
    output logic              adc_trig_o
);
    regs_t         r_d, r_q;
    logic          wr_en;
    logic          start, stop;
    logic          tick, sec_tick;
    logic          core_run, core_timeout, core_hit;
    logic [DW-1:0] core_count;
    logic [DW-1:0] load_val, match_val;
    logic [7:0]    set_v, clr_v;

    assign wr_en     = sel_i && wr_i;
    assign load_val  = {r_q.load_hi, r_q.load_lo};
    assign match_val = {r_q.match_hi, r_q.match_lo};

    assign start = wr_en && (int'(addr_i) == A_CTRL) &&  wdata_i[CTRL_RUN] && !r_q.ctrl[CTRL_RUN];
    assign stop  = wr_en && (int'(addr_i) == A_CTRL) && !wdata_i[CTRL_RUN] &&  r_q.ctrl[CTRL_RUN];

    // time bases: one for interval steps, one for seconds
    dmtimer_div #(.DIV(PRESCALE)) u_step_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (core_run),
        .restart_i (start),
        .tick_o    (tick)
    );

    dmtimer_div #(.DIV(CLKS_PER_SEC)) u_sec_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (core_run),
        .restart_i (start),
        .tick_o    (sec_tick)
    );

    dmtimer_core u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .stop_i    (stop),
        .cfg_i     (r_q.cfg),
        .oneshot_i (r_q.oneshot),
        .load_i    (load_val),
        .match_i   (match_val),
        .tick_i    (tick),
        .sec_i     (sec_tick),
        .run_o     (core_run),
        .count_o   (core_count),
        .timeout_o (core_timeout),
        .hit_o     (core_hit)
    );

    always_comb begin
        set_v          = '0;
        set_v[ST_TMO]  = core_timeout;
        set_v[ST_SECS] = core_hit;
        clr_v = (wr_en && int'(addr_i) == A_ICLR) ? wdata_i[7:0] : 8'h00;
    end

    always_comb begin
        r_d      = r_q;
        r_d.trig = core_timeout && r_q.ctrl[CTRL_TRG];
        r_d.ris  = (r_q.ris & ~clr_v) | set_v;
        if (wr_en) begin
            case (int'(addr_i))
                A_CFG:   r_d.cfg     = wdata_i[2:0];
                A_MODE:  r_d.oneshot = wdata_i[0];
                A_CTRL:  r_d.ctrl    = wdata_i[5:0] & CTRL_KEEP;
                A_IMASK: r_d.mask    = wdata_i[7:0] & MASK_KEEP;
                A_LOAD: begin
                    r_d.load_lo = wdata_i[HW-1:0];
                    r_d.load_hi = wdata_i[DW-1:HW];
                end
                A_MATCH: begin
                    r_d.match_lo = wdata_i[HW-1:0];
                    r_d.match_hi = wdata_i[DW-1:HW];
                end
                default: ;
            endcase
        end
        if (core_timeout && r_q.oneshot) begin
            r_d.ctrl[CTRL_RUN] = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (int'(addr_i))
            A_CFG:   rdata_o = {29'd0, r_q.cfg};
            A_MODE:  rdata_o = {31'd0, r_q.oneshot};
            A_CTRL:  rdata_o = {26'd0, r_q.ctrl};
            A_IMASK: rdata_o = {24'd0, r_q.mask};
            A_RIS:   rdata_o = {24'd0, r_q.ris};
            A_MIS:   rdata_o = {24'd0, r_q.ris & r_q.mask};
            A_LOAD:  rdata_o = {(r_q.cfg < CFG_SPLIT) ? r_q.load_hi : 16'h0, r_q.load_lo};
            A_MATCH: rdata_o = {(r_q.cfg < CFG_SPLIT) ? r_q.match_hi : 16'h0, r_q.match_lo};
            A_VALUE: rdata_o = core_count;
            default: rdata_o = '0;
        endcase
    end

    assign irq_o      = |(r_q.ris & r_q.mask);
    assign adc_trig_o = r_q.trig;
endmodule

// File: rtl/dmtimer_chk.sv
module dmtimer_chk
    import dmtimer_pkg::*;
#(
    parameter int unsigned PRESCALE = 4,
    parameter int unsigned ADDR_W   = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sel_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              clr0_i,
    input logic              trig_i,
    input logic              irq_i,
    input logic              run_i,
    input logic [DW-1:0]     count_i,
    input logic              timeout_i,
    input logic              oneshot_i,
    input logic              trg_en_i,
    input logic [7:0]        mask_i,
    input logic [7:0]        ris_i
);
    logic clr_hit;
    assign clr_hit = sel_i && wr_i && (int'(addr_i) == A_ICLR) && clr0_i;

    p_trig_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (PRESCALE > 1 && trig_i) |=> !trig_i);

    p_trig_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i |-> $past(trg_en_i));

    p_oneshot_halts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_i && oneshot_i) |=> !run_i);

    p_idle_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> ($stable(count_i) || run_i));

    p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == 8'h00) |-> !irq_i);

    p_status_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ris_i[ST_TMO] && !clr_hit) |=> ris_i[ST_TMO]);
endmodule

bind dmtimer dmtimer_chk #(.PRESCALE(PRESCALE), .ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .clr0_i    (wdata_i[0]),
    .trig_i    (adc_trig_o),
    .irq_i     (irq_o),
    .run_i     (core_run),
    .count_i   (core_count),
    .timeout_i (core_timeout),
    .oneshot_i (r_q.oneshot),
    .trg_en_i  (r_q.ctrl[5]),
    .mask_i    (r_q.mask),
    .ris_i     (r_q.ris)
);

// File: tb/dmtimer_bench.sv
module dmtimer_bench;
    localparam int PRE = 4;
    localparam int SEC = 16;

    typedef struct packed {
        logic [31:0] load;
        logic        oneshot;
        logic        trg;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'd3, 1'b0, 1'b1},
        '{32'd1, 1'b0, 1'b0},
        '{32'd5, 1'b1, 1'b1},
        '{32'd0, 1'b0, 1'b1},
        '{32'd2, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, trig;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    dmtimer #(.PRESCALE(PRE), .CLKS_PER_SEC(SEC), .ADDR_W(4)) u_dmtimer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sel_i      (sel),
        .wr_i       (wr),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq),
        .adc_trig_o (trig)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called just after a negedge; returns just after the following negedge
    task automatic wr_reg(input int a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_now(input int a, output logic [31:0] d);
        addr = 4'(a);
        #1;
        d = rdata;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 10; a++) begin
            @(negedge clk);
            rd_now(a, d);
            check("R1 register zero", d, 32'h0);
        end
        check("R1 irq low", {31'd0, irq}, 32'd0);
        check("R1 trig low", {31'd0, trig}, 32'd0);
        @(negedge clk);

        // table of countdown scenarios (R2, R3, R4, R5)
        for (int i = 0; i < 5; i++) begin
            t = PRE * ((VECS[i].load == 0) ? 1 : int'(VECS[i].load));
            wr_reg(2, 32'h0);
            wr_reg(6, 32'hFF);
            wr_reg(1, {31'd0, VECS[i].oneshot});
            wr_reg(0, 32'd0);
            wr_reg(7, VECS[i].load);
            wr_reg(3, 32'h1);
            wr_reg(2, 32'h1 | ({31'd0, VECS[i].trg} << 5));
            repeat (t - 1) @(negedge clk);
            check("R2 no early timeout", {31'd0, irq}, 32'd0);
            check("R5 no early strobe", {31'd0, trig}, 32'd0);
            @(negedge clk);
            check("R2 timeout on time", {31'd0, irq}, 32'd1);
            check("R5 strobe follows enable", {31'd0, trig}, {31'd0, VECS[i].trg});
            @(negedge clk);
            check("R5 strobe one cycle", {31'd0, trig}, 32'd0);
            if (VECS[i].oneshot) begin
                rd_now(2, d);
                check("R4 run bit cleared", {31'd0, d[0]}, 32'd0);
                rd_now(9, d);
                check("R4 counter zero", d, 32'd0);
                wr_reg(6, 32'h1);
                repeat (t) @(negedge clk);
                check("R4 no second timeout", {31'd0, irq}, 32'd0);
            end else begin
                wr_reg(6, 32'h1);
                repeat (t - 3) @(negedge clk);
                check("R3 not before period", {31'd0, irq}, 32'd0);
                @(negedge clk);
                check("R3 periodic timeout", {31'd0, irq}, 32'd1);
            end
        end

        // R9: split halves and readback rule
        wr_reg(2, 32'h0);
        wr_reg(0, 32'd0);
        wr_reg(7, 32'hABCD_1234);
        wr_reg(8, 32'h5A5A_0F0F);
        rd_now(7, d); check("R9 interval full", d, 32'hABCD_1234);
        rd_now(8, d); check("R9 compare full", d, 32'h5A5A_0F0F);
        @(negedge clk);
        wr_reg(0, 32'd4);
        rd_now(7, d); check("R9 interval lower only", d, 32'h0000_1234);
        rd_now(8, d); check("R9 compare lower only", d, 32'h0000_0F0F);
        @(negedge clk);

        // R7: mask filter
        wr_reg(3, 32'hFFFF_FFFF);
        rd_now(3, d); check("R7 mask keeps 0x77", d, 32'h77);
        @(negedge clk);

        // R6: seconds mode with compare 3
        wr_reg(6, 32'hFF);
        wr_reg(0, 32'd1);
        wr_reg(8, 32'd3);
        wr_reg(3, 32'h4);
        wr_reg(2, 32'h1);
        repeat (3 * SEC - 1) @(negedge clk);
        check("R6 no early hit", {31'd0, irq}, 32'd0);
        rd_now(9, d); check("R6 count before hit", d, 32'd2);
        @(negedge clk);
        check("R6 hit raises irq", {31'd0, irq}, 32'd1);
        rd_now(9, d); check("R6 count at hit", d, 32'd3);
        rd_now(5, d); check("R7 masked status", d, 32'h4);
        repeat (SEC) @(negedge clk);
        rd_now(9, d); check("R6 keeps counting", d, 32'd4);
        check("R6 flag sticky", {31'd0, irq}, 32'd1);
        @(negedge clk);
        wr_reg(3, 32'h0);
        check("R7 mask hides irq", {31'd0, irq}, 32'd0);
        rd_now(4, d); check("R7 raw status kept", d, 32'h4);
        rd_now(5, d); check("R7 masked status zero", d, 32'h0);
        @(negedge clk);
        wr_reg(3, 32'h4);
        wr_reg(6, 32'h0);
        check("R8 zero clear no effect", {31'd0, irq}, 32'd1);
        wr_reg(6, 32'h4);
        check("R8 clear drops irq", {31'd0, irq}, 32'd0);

        // R10: stop freezes, bad config start stays idle
        wr_reg(2, 32'h0);
        wr_reg(6, 32'hFF);
        wr_reg(0, 32'd0);
        wr_reg(1, 32'd0);
        wr_reg(7, 32'd100);
        wr_reg(3, 32'h1);
        wr_reg(2, 32'h1);
        repeat (20) @(negedge clk);
        wr_reg(2, 32'h0);
        rd_now(9, d); check("R10 value at stop", d, 32'd95);
        repeat (50) @(negedge clk);
        rd_now(9, d); check("R10 value frozen", d, 32'd95);
        check("R10 no timeout when stopped", {31'd0, irq}, 32'd0);
        @(negedge clk);
        wr_reg(0, 32'd2);
        wr_reg(2, 32'h1);
        repeat (20) @(negedge clk);
        rd_now(9, d); check("R10 unsupported config idle", d, 32'd95);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule